// File: doc/BRIEF.md
# Core Module Control Register File

This block is the control and identification register file of a processor core module. It sits on a simple 32-bit register bus with separate read and write strobes, a word index and write data. It holds the clock-synthesizer settings, the module control word, the SDRAM and initialisation settings, and two banks of software flags. It also holds a small local interrupt mask whose only source is a software-set request bit.

Writes to both clock-synthesizer words need a 16-bit unlock key to be held in the lock word first. The control word drives three things: the misc LED output, a flash-enable output that a remap bit can withdraw so RAM appears at address zero, and a one-cycle system reset request. Read data comes back registered, one cycle after the read strobe. An error output flags any access to a word the block does not implement. The installed memory size is an elaboration parameter that shapes the SDRAM reset value.

Top module: `cm_regfile`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Words 32 to 35 and the window of words 64 to 127 read 0 without error. Writes to words 32 to 35 are accepted without error and have no effect.
- R2: The lock word (word 5) keeps only bits 15:0 of a write. While it holds 0xA05F, it reads 0x0001A05F (bit 16 is the unlocked status). Otherwise it reads the stored 16-bit value.
- R3: Writes to the synthesizer word (word 2) and the auxiliary synthesizer word (word 7) update them only while the lock word holds 0xA05F. At any other time these writes leave the stored value unchanged.
- R4: The control word (word 3) stores only bits 0 and 2, and reads back with every other bit zero, bit 3 included. `led_out` follows stored bit 0.
- R5: `flash_en` is the inverse of stored control bit 2: it is 1 after reset and 0 after a control write with bit 2 set.
- R6: A control write with bit 3 set raises `sys_rst_req` for exactly the one cycle after the write edge. No other access raises it.
- R7: Words 12 and 13 set and clear bits of the flag word. Words 14 and 15 do the same for the second flag word. Words 12 and 14 read the current values, and both flag words reset to 0.
- R8: Reset values are 0x01000048 for word 2, 0x0007FEFF for word 7 and 0x00000112 for word 9. Word 8 resets to 0x00011122 ORed with a size code taken from MEM_MB: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise. With the default MEM_MB of 64, word 8 resets to 0x0001112A.
- R9: The SDRAM word (word 8) and the init word (word 9) store and read back a full 32-bit write.
- R10: Word 18 sets IRQ enable bits and reads them back, and word 19 clears them. Word 16 reads the request level ANDed with the IRQ enables, and word 17 reads the raw level. `irq_out` is high when any enabled bit has its level set.
- R11: Words 24 to 27 do the same for FIQ: 24 is the masked status, 25 the raw level, 26 the enable set and readback, and 27 the enable clear. `fiq_out` is high when any FIQ-enabled bit has its level set.
- R12: A write to word 20 with bit 0 set raises request level bit 0, and a write to word 21 with bit 0 set clears it. Other bits of these writes are ignored. Word 20 reads the level (bit 0 only).
- R13: Any access to a word not listed in R1 to R12 raises `rsp_err` for the cycle after the access, and such a read returns 0. This covers words 6 and 10, writes to read-only words (0, 1, 4, 16, 17, 24, 25) and any write into words 64 to 127.
- R14: A read returns `rsp_valid` with its data in the cycle after the strobe. When a read and a write fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | ADDR_W | Word index |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rsp_err | output | 1 | Unimplemented access, one cycle after the strobe |
| flash_en | output | 1 | Flash mapped at address zero |
| led_out | output | 1 | Misc LED |
| sys_rst_req | output | 1 | One-cycle system reset request |
| irq_out | output | 1 | Local IRQ request |
| fiq_out | output | 1 | Local FIQ request |

## Verification
A single control write can hit three effects in the same cycle: it can set the reset bit, set the remap bit and set the LED bit. The bench issues one such write. It then checks that `sys_rst_req`, `flash_en` and `led_out` all change together on the next cycle, that the reset pulse is gone one cycle later, and that the readback still shows bit 3 as zero. A read and a write to the same word are also driven in one cycle. The read must return the value from before the write, and a second read must show the new value.

// File: rtl/cm_regfile_pkg.sv
package cm_regfile_pkg;

  localparam logic [31:0] W_ID        = 32'd0;
  localparam logic [31:0] W_PROC      = 32'd1;
  localparam logic [31:0] W_OSC       = 32'd2;
  localparam logic [31:0] W_CTRL      = 32'd3;
  localparam logic [31:0] W_STAT      = 32'd4;
  localparam logic [31:0] W_LOCK      = 32'd5;
  localparam logic [31:0] W_AUX       = 32'd7;
  localparam logic [31:0] W_SDRAM     = 32'd8;
  localparam logic [31:0] W_INIT      = 32'd9;
  localparam logic [31:0] W_FLG_SET   = 32'd12;
  localparam logic [31:0] W_FLG_CLR   = 32'd13;
  localparam logic [31:0] W_NV_SET    = 32'd14;
  localparam logic [31:0] W_NV_CLR    = 32'd15;
  localparam logic [31:0] W_IRQ_STAT  = 32'd16;
  localparam logic [31:0] W_IRQ_RAW   = 32'd17;
  localparam logic [31:0] W_IRQ_SET   = 32'd18;
  localparam logic [31:0] W_IRQ_CLR   = 32'd19;
  localparam logic [31:0] W_SOFT_SET  = 32'd20;
  localparam logic [31:0] W_SOFT_CLR  = 32'd21;
  localparam logic [31:0] W_FIQ_STAT  = 32'd24;
  localparam logic [31:0] W_FIQ_RAW   = 32'd25;
  localparam logic [31:0] W_FIQ_SET   = 32'd26;
  localparam logic [31:0] W_FIQ_CLR   = 32'd27;
  localparam logic [31:0] W_VOLT_LO   = 32'd32;
  localparam logic [31:0] W_VOLT_HI   = 32'd35;
  localparam logic [31:0] W_SPD_LO    = 32'd64;
  localparam logic [31:0] W_SPD_HI    = 32'd127;

  localparam logic [31:0] ID_VALUE    = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST     = 32'h0100_0048;
  localparam logic [31:0] AUX_RST     = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST    = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;

  // Number of set/clear banks built by the generate loop in the top.
  localparam int unsigned N_BANKS = 4;
  localparam int unsigned B_FLAGS = 0;
  localparam int unsigned B_NV    = 1;
  localparam int unsigned B_IRQEN = 2;
  localparam int unsigned B_FIQEN = 3;

  // Decoded write strobes, one bit per writable function.
  typedef struct packed {
    logic osc;
    logic ctrl;
    logic lock;
    logic aux;
    logic sdram;
    logic init;
    logic soft_set;
    logic soft_clr;
    logic [N_BANKS-1:0] bank_set;
    logic [N_BANKS-1:0] bank_clr;
  } wr_strobe_t;

  function automatic logic [31:0] sdram_size_code(int unsigned mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/cm_lock_osc.sv
module cm_lock_osc
  import cm_regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock_we,
  input  logic        osc_we,
  input  logic        aux_we,
  input  logic [31:0] wdata,
  output logic [15:0] lock_q,
  output logic        unlocked,
  output logic [31:0] osc_q,
  output logic [31:0] aux_q
);

  logic [15:0] lock_d;
  logic [31:0] osc_d;
  logic [31:0] aux_d;

  assign unlocked = (lock_q == UNLOCK_KEY);

  always_comb begin
    lock_d = lock_q;
    osc_d  = osc_q;
    aux_d  = aux_q;
    if (lock_we) lock_d = wdata[15:0];
    if (osc_we && unlocked) osc_d = wdata;
    if (aux_we && unlocked) aux_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      osc_q  <= OSC_RST;
      aux_q  <= AUX_RST;
    end else begin
      lock_q <= lock_d;
      osc_q  <= osc_d;
      aux_q  <= aux_d;
    end
  end

endmodule

// File: rtl/cm_ctrl_reg.sv
module cm_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic wr_led,
  input  logic wr_remap,
  input  logic wr_reset,
  output logic led_q,
  output logic remap_q,
  output logic flash_en,
  output logic rst_pulse
);

  logic led_d;
  logic remap_d;
  logic pulse_d;

  always_comb begin
    led_d   = led_q;
    remap_d = remap_q;
    pulse_d = 1'b0;
    if (ctrl_we) begin
      led_d   = wr_led;
      remap_d = wr_remap;
      pulse_d = wr_reset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      led_q     <= led_d;
      remap_q   <= remap_d;
      rst_pulse <= pulse_d;
    end
  end

  assign flash_en = !remap_q;

endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] d;

  always_comb begin
    d = q;
    if (set_we) d = d | wdata;
    if (clr_we) d = d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
  import cm_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned MEM_MB = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              flash_en,
  output logic              led_out,
  output logic              sys_rst_req,
  output logic              irq_out,
  output logic              fiq_out
);

  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

  logic [31:0] idx;
  wr_strobe_t  wst;
  logic        rd_ok;
  logic        wr_ok;
  logic [31:0] rd_mux;

  logic [15:0] lock_q;
  logic        osc_unlocked;
  logic [31:0] osc_q;
  logic [31:0] aux_q;
  logic        led_q;
  logic        remap_q;
  logic [31:0] sdram_q, sdram_d;
  logic [31:0] init_q, init_d;
  logic        soft_q;
  logic [31:0] level;
  logic [31:0] bank_q [N_BANKS];

  logic [31:0] rdata_d;
  logic        valid_d;
  logic        err_d;

  assign idx = 32'(req_addr);

  // ---------------- write decode ----------------
  always_comb begin
    wst   = '0;
    wr_ok = 1'b1;
    unique case (idx)
      W_OSC:      wst.osc  = 1'b1;
      W_CTRL:     wst.ctrl = 1'b1;
      W_LOCK:     wst.lock = 1'b1;
      W_AUX:      wst.aux  = 1'b1;
      W_SDRAM:    wst.sdram = 1'b1;
      W_INIT:     wst.init  = 1'b1;
      W_FLG_SET:  wst.bank_set[B_FLAGS] = 1'b1;
      W_FLG_CLR:  wst.bank_clr[B_FLAGS] = 1'b1;
      W_NV_SET:   wst.bank_set[B_NV]    = 1'b1;
      W_NV_CLR:   wst.bank_clr[B_NV]    = 1'b1;
      W_IRQ_SET:  wst.bank_set[B_IRQEN] = 1'b1;
      W_IRQ_CLR:  wst.bank_clr[B_IRQEN] = 1'b1;
      W_FIQ_SET:  wst.bank_set[B_FIQEN] = 1'b1;
      W_FIQ_CLR:  wst.bank_clr[B_FIQEN] = 1'b1;
      W_SOFT_SET: wst.soft_set = 1'b1;
      W_SOFT_CLR: wst.soft_clr = 1'b1;
      default:    wr_ok = (idx >= W_VOLT_LO) && (idx <= W_VOLT_HI);
    endcase
    if (!req_wr) wst = '0;
  end

  // ---------------- storage ----------------
  cm_lock_osc u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_we  (wst.lock),
    .osc_we   (wst.osc),
    .aux_we   (wst.aux),
    .wdata    (req_wdata),
    .lock_q   (lock_q),
    .unlocked (osc_unlocked),
    .osc_q    (osc_q),
    .aux_q    (aux_q)
  );

  cm_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (wst.ctrl),
    .wr_led    (req_wdata[0]),
    .wr_remap  (req_wdata[2]),
    .wr_reset  (req_wdata[3]),
    .led_q     (led_q),
    .remap_q   (remap_q),
    .flash_en  (flash_en),
    .rst_pulse (sys_rst_req)
  );

  assign led_out = led_q;

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      cm_setclr_reg #(.WIDTH(32)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wst.bank_set[b]),
        .clr_we (wst.bank_clr[b]),
        .wdata  (req_wdata),
        .q      (bank_q[b])
      );
    end
  endgenerate

  cm_setclr_reg #(.WIDTH(1)) u_soft (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wst.soft_set),
    .clr_we (wst.soft_clr),
    .wdata  (req_wdata[0]),
    .q      (soft_q)
  );

  always_comb begin
    sdram_d = sdram_q;
    init_d  = init_q;
    if (wst.sdram) sdram_d = req_wdata;
    if (wst.init)  init_d  = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
    end else begin
      sdram_q <= sdram_d;
      init_q  <= init_d;
    end
  end

  // ---------------- interrupt outputs ----------------
  assign level   = {31'b0, soft_q};
  assign irq_out = |(level & bank_q[B_IRQEN]);
  assign fiq_out = |(level & bank_q[B_FIQEN]);

  // ---------------- read mux ----------------
  always_comb begin
    rd_mux = '0;
    rd_ok  = 1'b1;
    unique case (idx)
      W_ID:       rd_mux = ID_VALUE;
      W_PROC:     rd_mux = '0;
      W_OSC:      rd_mux = osc_q;
      W_CTRL:     rd_mux = {29'b0, remap_q, 1'b0, led_q};
      W_STAT:     rd_mux = STAT_VALUE;
      W_LOCK:     rd_mux = {15'b0, osc_unlocked, lock_q};
      W_AUX:      rd_mux = aux_q;
      W_SDRAM:    rd_mux = sdram_q;
      W_INIT:     rd_mux = init_q;
      W_FLG_SET:  rd_mux = bank_q[B_FLAGS];
      W_NV_SET:   rd_mux = bank_q[B_NV];
      W_IRQ_STAT: rd_mux = level & bank_q[B_IRQEN];
      W_IRQ_RAW:  rd_mux = level;
      W_IRQ_SET:  rd_mux = bank_q[B_IRQEN];
      W_SOFT_SET: rd_mux = level;
      W_FIQ_STAT: rd_mux = level & bank_q[B_FIQEN];
      W_FIQ_RAW:  rd_mux = level;
      W_FIQ_SET:  rd_mux = bank_q[B_FIQEN];
      default: begin
        rd_mux = '0;
        rd_ok  = ((idx >= W_VOLT_LO) && (idx <= W_VOLT_HI)) ||
                 ((idx >= W_SPD_LO)  && (idx <= W_SPD_HI));
      end
    endcase
  end

  // ---------------- response register ----------------
  always_comb begin
    valid_d = req_rd;
    rdata_d = (req_rd && rd_ok) ? rd_mux : 32'h0;
    err_d   = (req_rd && !rd_ok) || (req_wr && !wr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rdata_d;
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
    end
  end

endmodule

// File: rtl/cm_regfile_chk.sv
module cm_regfile_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              flash_en,
  input logic              sys_rst_req,
  input logic              irq_out,
  input logic [31:0]       osc_q,
  input logic              osc_unlocked
);

  logic [31:0] a;
  logic        ctrl_wr;
  assign a       = 32'(req_addr);
  assign ctrl_wr = req_wr && (a == 32'd3);

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && a == 32'd5 && req_wdata[15:0] == 16'hA05F) |=> osc_unlocked);

  assert_locked_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && a == 32'd2 && !osc_unlocked) |=> $stable(osc_q));

  assert_remap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (flash_en == !$past(req_wdata[2])));

  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && req_wdata[3]) |=> sys_rst_req);

  assert_no_spurious_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && req_wdata[3]) |=> !sys_rst_req);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && a == 32'd19 && req_wdata[0]) |=> !irq_out);

  assert_timer_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && (a == 32'd6 || a == 32'd10)) |=> rsp_err);

  assert_read_valid_R14: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);

  assert_no_stray_valid_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid);

endmodule

bind cm_regfile cm_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_rd       (req_rd),
  .req_wr       (req_wr),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .flash_en     (flash_en),
  .sys_rst_req  (sys_rst_req),
  .irq_out      (irq_out),
  .osc_q        (osc_q),
  .osc_unlocked (osc_unlocked)
);

// File: tb/cm_regfile_tb.sv
module cm_regfile_tb;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned MEM_MB = 64;
  localparam time CLK_PERIOD = 10ns;

  logic              clk;
  logic              rst_n;
  logic              req_rd;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic [31:0]       rsp_rdata;
  logic              rsp_valid;
  logic              rsp_err;
  logic              flash_en;
  logic              led_out;
  logic              sys_rst_req;
  logic              irq_out;
  logic              fiq_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  cm_regfile #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_rd      (req_rd),
    .req_wr      (req_wr),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_rdata   (rsp_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .flash_en    (flash_en),
    .led_out     (led_out),
    .sys_rst_req (sys_rst_req),
    .irq_out     (irq_out),
    .fiq_out     (fiq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  // Monitor: pops expected read responses as they appear.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R14 unexpected response actual=0x%08h expected=none", rsp_rdata);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({31'b0, rsp_err}, {31'b0, e[32]}, {t, " err"});
        chk(rsp_rdata, e[31:0], t);
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] exp, input logic e, input string tag);
    @(negedge clk);
    req_rd   = 1'b1;
    req_addr = ADDR_W'(a);
    exp_q.push_back({e, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    req_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_wr    = 1'b1;
    req_addr  = ADDR_W'(a);
    req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic wr_err(input int a, input logic [31:0] d, input logic e, input string tag);
    @(negedge clk);
    req_wr    = 1'b1;
    req_addr  = ADDR_W'(a);
    req_wdata = d;
    @(negedge clk);
    chk({31'b0, rsp_err}, {31'b0, e}, tag);
    req_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] sdram_exp;
    sdram_exp = 32'h0001_1122 | 32'h08;  // MEM_MB=64 size code per R8
    rst_n = 1'b0; req_rd = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    @(negedge clk);
    chk({31'b0, flash_en},    32'd1, "R5 reset flash_en");
    chk({31'b0, led_out},     32'd0, "R4 reset led");
    chk({31'b0, sys_rst_req}, 32'd0, "R6 reset pulse");
    chk({31'b0, irq_out},     32'd0, "R10 reset irq");
    chk({31'b0, fiq_out},     32'd0, "R11 reset fiq");
    chk({31'b0, rsp_err},     32'd0, "R13 reset err");
    rd(0,  32'h411A_3001, 0, "R1 id");
    rd(1,  32'h0,         0, "R1 proc");
    rd(4,  32'h0010_0000, 0, "R1 status");
    rd(2,  32'h0100_0048, 0, "R8 osc reset");
    rd(7,  32'h0007_FEFF, 0, "R8 aux reset");
    rd(9,  32'h0000_0112, 0, "R8 init reset");
    rd(8,  sdram_exp,     0, "R8 sdram reset");
    rd(5,  32'h0,         0, "R2 lock reset");
    rd(12, 32'h0,         0, "R7 flags reset");
    rd(14, 32'h0,         0, "R7 nvflags reset");

    // Lock gating
    wr(2, 32'h1234_5678);
    rd(2, 32'h0100_0048, 0, "R3 locked osc ignored");
    wr(5, 32'hFFFF_A05F);
    rd(5, 32'h0001_A05F, 0, "R2 unlocked readback");
    wr(2, 32'h1234_5678);
    rd(2, 32'h1234_5678, 0, "R3 unlocked osc");
    wr(7, 32'hCAFE_0001);
    rd(7, 32'hCAFE_0001, 0, "R3 unlocked aux");
    wr(5, 32'hABCD_1234);
    rd(5, 32'h0000_1234, 0, "R2 low 16 stored");
    wr(7, 32'h5555_5555);
    rd(7, 32'hCAFE_0001, 0, "R3 relocked aux ignored");

    // Control: reset + remap + LED in one write
    @(negedge clk);
    req_wr = 1'b1; req_addr = ADDR_W'(3); req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_wr = 1'b0;
    chk({31'b0, sys_rst_req}, 32'd1, "R6 pulse high");
    chk({31'b0, flash_en},    32'd0, "R5 remap drops flash");
    chk({31'b0, led_out},     32'd1, "R4 led on");
    @(negedge clk);
    chk({31'b0, sys_rst_req}, 32'd0, "R6 pulse one cycle");
    rd(3, 32'h0000_0005, 0, "R4 ctrl readback bit3 zero");
    wr(3, 32'h0000_0000);
    chk({31'b0, flash_en},    32'd1, "R5 flash back");
    chk({31'b0, led_out},     32'd0, "R4 led off");
    chk({31'b0, sys_rst_req}, 32'd0, "R6 no pulse without bit3");

    // Flags
    wr(12, 32'h0000_00F0);
    wr(12, 32'h0000_000F);
    wr(13, 32'h0000_003C);
    rd(12, 32'h0000_00C3, 0, "R7 flags set/clear");
    wr(14, 32'h8000_0001);
    wr(15, 32'h0000_0001);
    rd(14, 32'h8000_0000, 0, "R7 nvflags set/clear");
    rd(12, 32'h0000_00C3, 0, "R7 flags untouched by nv");

    // SDRAM / init
    wr(8, 32'hDEAD_BEEF);
    rd(8, 32'hDEAD_BEEF, 0, "R9 sdram write");
    wr(9, 32'h0BAD_F00D);
    rd(9, 32'h0BAD_F00D, 0, "R9 init write");

    // Interrupts
    wr(18, 32'h0000_0003);
    rd(18, 32'h0000_0003, 0, "R10 irq enable readback");
    chk({31'b0, irq_out}, 32'd0, "R10 no level no irq");
    wr(20, 32'hFFFF_FFFF);
    rd(20, 32'h0000_0001, 0, "R12 soft set only bit0");
    rd(17, 32'h0000_0001, 0, "R10 raw level");
    rd(16, 32'h0000_0001, 0, "R10 irq status");
    chk({31'b0, irq_out}, 32'd1, "R10 irq asserted");
    chk({31'b0, fiq_out}, 32'd0, "R11 fiq masked");
    wr(26, 32'h0000_0001);
    rd(26, 32'h0000_0001, 0, "R11 fiq enable readback");
    rd(24, 32'h0000_0001, 0, "R11 fiq status");
    rd(25, 32'h0000_0001, 0, "R11 fiq raw");
    chk({31'b0, fiq_out}, 32'd1, "R11 fiq asserted");
    wr(19, 32'h0000_0001);
    rd(18, 32'h0000_0002, 0, "R10 irq enable clear");
    rd(16, 32'h0000_0000, 0, "R10 irq status masked");
    chk({31'b0, irq_out}, 32'd0, "R10 irq deasserted");
    wr(21, 32'hFFFF_FFFE);
    rd(20, 32'h0000_0001, 0, "R12 clear without bit0 ignored");
    wr(21, 32'h0000_0001);
    rd(20, 32'h0000_0000, 0, "R12 soft clear");
    chk({31'b0, fiq_out}, 32'd0, "R11 fiq drops with level");
    wr(27, 32'h0000_0001);
    rd(26, 32'h0000_0000, 0, "R11 fiq enable clear");

    // Reserved / unimplemented
    rd(33,  32'h0, 0, "R1 voltage reads zero");
    wr_err(33, 32'hFFFF_FFFF, 0, "R1 voltage write accepted");
    rd(33,  32'h0, 0, "R1 voltage write no effect");
    rd(80,  32'h0, 0, "R1 spd window zero");
    rd(6,   32'h0, 1, "R13 timer word error");
    rd(40,  32'h0, 1, "R13 unmapped read error");
    wr_err(0,  32'h1, 1, "R13 write read-only error");
    wr_err(70, 32'h1, 1, "R13 write spd error");
    wr_err(10, 32'h1, 1, "R13 write timer error");

    // Same-cycle read and write
    @(negedge clk);
    req_rd = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(5); req_wdata = 32'h0000_0777;
    exp_q.push_back({1'b0, 32'h0000_1234});
    tag_q.push_back("R14 read returns pre-write value");
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    rd(5, 32'h0000_0777, 0, "R14 write landed");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R14 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule